// File: doc/BRIEF.md
# Prescaled Watchdog Timer with Reload

This block is a fail-safe supervisor for a processor subsystem. A 16-bit up-counter advances on a count clock taken from the system clock through a prescaler that divides by 2 or by 128. Software keeps the system alive by strobing a service input. Each service writes an 8-bit reload value into the counter's upper byte and clears both the lower byte and the prescaler. The reload value therefore sets the length of the monitored interval. That interval runs from 256 count ticks (reload 0xFF at divide-by-2) up to 65536 ticks (reload 0x00 at divide-by-128).

The watchdog is running when it leaves reset. Boot code may switch it off, but only during the start-up phase. Once an end-of-initialization strobe has been seen, every later disable request is ignored until the next reset.

If the counter wraps past 0xFFFF, the block raises an internal reset request and pulls its active-low reset output low. This lasts for a fixed, parameterized number of system clocks. The block then returns to its post-reset condition: the count is zero, the watchdog is enabled, and the start-up window is open again.

Top module: `wdog_prescaled`

## Requirements
- R1: After the asynchronous reset is released, count_o reads 0, rst_req_o is 0, rst_out_no is 1, and the counter is running.
- R2: With div_sel_i = 0, count_o increases by one every 2 system clocks. With div_sel_i = 1, it increases by one every 128 system clocks.
- R3: A service strobe (svc_i high for one clock) makes count_o equal to {reload_i, 8'h00} on the next cycle. It also clears the prescaler, so the next increment comes a full prescale period (2 or 128 clocks) after the service.
- R4: When a count tick occurs while count_o is 0xFFFF, rst_req_o goes to 1 and rst_out_no goes to 0 on the next cycle. Both stay there for exactly PULSE_CYCLES clocks (default 8).
- R5: While the reset pulse is active, count_o stays at 0, and svc_i, dis_i and einit_i have no effect.
- R6: When the reset pulse ends, the block is back in its post-reset state. Counting restarts from 0, and the disable window is open again.
- R7: A dis_i strobe accepted before any end-of-init stops the counter from advancing. The counter stays stopped until rst_ni, and no overflow occurs. A service while stopped still loads {reload_i, 8'h00}.
- R8: After einit_i has been strobed, a later dis_i is ignored and counting continues. If einit_i and dis_i arrive in the same clock, the disable is also ignored.
- R9: If svc_i coincides with the overflowing tick, the overflow takes effect and the service is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| svc_i | input | 1 | Service strobe; reloads the upper byte |
| dis_i | input | 1 | Disable request, honoured only before end-of-init |
| einit_i | input | 1 | End-of-initialization strobe; closes the disable window |
| div_sel_i | input | 1 | Prescale select: 0 = divide by 2, 1 = divide by 128 |
| reload_i | input | 8 | Value loaded into the counter's upper byte on service |
| count_o | output | 16 | Current counter value |
| rst_req_o | output | 1 | Internal reset request, high during the reset pulse |
| rst_out_no | output | 1 | Active-low reset output for external devices |

## Verification
The bound checker watches several rules on every clock:
- the counter only ever holds or steps by one;
- a service lands the reload value in the upper byte;
- the count stays at zero during the pulse;
- a pulse starts only from a count of 0xFFFF;
- a pulse lasts exactly the configured length.

Some behaviours depend on history, and only the bench's scenarios can show them. These are the sticky end-of-init lock, the disable that persists, the restored start-up window after a pulse, and the overflow-beats-service collision. The bench checks them against a behavioural reference model that it compares on every clock, plus targeted interval checks at both prescale settings.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Phase of the reset-pulse generator
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_HOLD = 1'b1
  } wd_phase_e;

  // Prescale selection encoding
  typedef enum logic {
    DIV_FAST = 1'b0,
    DIV_SLOW = 1'b1
  } wd_div_e;

endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned FAST_DIV = 2,
  parameter int unsigned SLOW_DIV = 128
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  input  logic slow_i,
  output logic tick_o
);
  import wdog_pkg::*;

  localparam int unsigned PRE_W = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [PRE_W-1:0] LIM_FAST = PRE_W'(FAST_DIV - 1);
  localparam logic [PRE_W-1:0] LIM_SLOW = PRE_W'(SLOW_DIV - 1);

  logic [PRE_W-1:0] pre_q, pre_d, limit;
  logic             pre_en;

  assign limit  = (wd_div_e'(slow_i) == DIV_SLOW) ? LIM_SLOW : LIM_FAST;
  assign tick_o = run_i && (pre_q >= limit);
  assign pre_en = clr_i | run_i;

  always_comb begin
    pre_d = pre_q;
    if (clr_i) begin
      pre_d = '0;
    end else if (run_i) begin
      if (tick_o) pre_d = '0;
      else        pre_d = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned RLD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic             clear_i,
  input  logic [RLD_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o
);
  localparam int unsigned LOW_W = CNT_W - RLD_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = clear_i | load_i | tick_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)     cnt_d = '0;
    else if (load_i) cnt_d = {reload_i, {LOW_W{1'b0}}};
    else if (tick_i) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
  assign full_o  = &cnt_q;

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic hold_i,
  input  logic dis_i,
  input  logic einit_i,
  output logic en_o
);
  logic en_q, en_d;
  logic lock_q, lock_d;
  logic upd;

  assign upd = restart_i | ~hold_i;

  always_comb begin
    en_d   = en_q;
    lock_d = lock_q;
    if (restart_i) begin
      en_d   = 1'b1;
      lock_d = 1'b0;
    end else if (!hold_i) begin
      lock_d = lock_q | einit_i;
      if (dis_i && !lock_q && !einit_i) en_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b1;
      lock_q <= 1'b0;
    end else if (upd) begin
      en_q   <= en_d;
      lock_q <= lock_d;
    end
  end

  assign en_o = en_q;

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int unsigned PULSE_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o,
  output logic done_o
);
  import wdog_pkg::*;

  generate
    if (PULSE_CYCLES <= 1) begin : g_single
      logic act_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) act_q <= 1'b0;
        else         act_q <= act_q ? 1'b0 : start_i;
      end
      assign active_o = act_q;
      assign done_o   = act_q;
    end else begin : g_multi
      localparam int unsigned REM_W = $clog2(PULSE_CYCLES);
      wd_phase_e        ph_q, ph_d;
      logic [REM_W-1:0] rem_q, rem_d;

      always_comb begin
        ph_d  = ph_q;
        rem_d = rem_q;
        case (ph_q)
          PH_IDLE: if (start_i) begin
            ph_d  = PH_HOLD;
            rem_d = REM_W'(PULSE_CYCLES - 1);
          end
          PH_HOLD: begin
            if (rem_q == '0) ph_d = PH_IDLE;
            else             rem_d = rem_q - REM_W'(1);
          end
          default: ph_d = PH_IDLE;
        endcase
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ph_q  <= PH_IDLE;
          rem_q <= '0;
        end else begin
          ph_q  <= ph_d;
          rem_q <= rem_d;
        end
      end

      assign active_o = (ph_q == PH_HOLD);
      assign done_o   = (ph_q == PH_HOLD) && (rem_q == '0);
    end
  endgenerate

endmodule

// File: rtl/wdog_prescaled.sv
module wdog_prescaled #(
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned RLD_W        = 8,
  parameter int unsigned FAST_DIV     = 2,
  parameter int unsigned SLOW_DIV     = 128,
  parameter int unsigned PULSE_CYCLES = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             svc_i,
  input  logic             dis_i,
  input  logic             einit_i,
  input  logic             div_sel_i,
  input  logic [RLD_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             rst_req_o,
  output logic             rst_out_no
);
  logic en, run, tick, full, ovf, svc_ok;
  logic active, done, pre_clr, cnt_clr;

  assign run     = en & ~active;
  assign ovf     = tick & full;
  assign svc_ok  = svc_i & ~active;
  assign cnt_clr = ovf | done;
  assign pre_clr = cnt_clr | svc_ok;

  wdog_prescaler #(
    .FAST_DIV(FAST_DIV),
    .SLOW_DIV(SLOW_DIV)
  ) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .clr_i (pre_clr),
    .slow_i(div_sel_i),
    .tick_o(tick)
  );

  wdog_counter #(
    .CNT_W(CNT_W),
    .RLD_W(RLD_W)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .load_i  (svc_ok),
    .clear_i (cnt_clr),
    .reload_i(reload_i),
    .count_o (count_o),
    .full_o  (full)
  );

  wdog_guard u_guard (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(done),
    .hold_i   (active),
    .dis_i    (dis_i),
    .einit_i  (einit_i),
    .en_o     (en)
  );

  wdog_pulse #(
    .PULSE_CYCLES(PULSE_CYCLES)
  ) u_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (ovf),
    .active_o(active),
    .done_o  (done)
  );

  assign rst_req_o  = active;
  assign rst_out_no = ~active;

endmodule

// File: rtl/wdog_prescaled_chk.sv
module wdog_prescaled_chk #(
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned RLD_W        = 8,
  parameter int unsigned PULSE_CYCLES = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             svc_i,
  input logic [RLD_W-1:0] reload_i,
  input logic [CNT_W-1:0] count_o,
  input logic             rst_req_o,
  input logic             rst_out_no
);
  localparam int unsigned LOW_W = CNT_W - RLD_W;

  int len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        len_q <= 0;
    else if (rst_req_o) len_q <= len_q + 1;
    else                len_q <= 0;
  end

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_req_o && !svc_i) |=> (rst_req_o || count_o == $past(count_o) ||
                                count_o == $past(count_o) + CNT_W'(1))); // R2

  AST_SERVICE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_i && !rst_req_o) |=> (rst_req_o ||
                               count_o == {$past(reload_i), {LOW_W{1'b0}}})); // R3

  AST_PULSE_FROM_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_out_no) |-> $past(count_o) == {CNT_W{1'b1}}); // R4

  AST_PULSE_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_o) |-> len_q == PULSE_CYCLES); // R4

  AST_PULSE_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> len_q < PULSE_CYCLES); // R4

  AST_HOLD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> count_o == '0); // R5

endmodule

bind wdog_prescaled wdog_prescaled_chk #(
  .CNT_W       (CNT_W),
  .RLD_W       (RLD_W),
  .PULSE_CYCLES(PULSE_CYCLES)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .svc_i     (svc_i),
  .reload_i  (reload_i),
  .count_o   (count_o),
  .rst_req_o (rst_req_o),
  .rst_out_no(rst_out_no)
);

// File: tb/wdog_prescaled_bench.sv
module wdog_prescaled_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int PULSE = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        svc = 1'b0, dis = 1'b0, einit = 1'b0, sel = 1'b0;
  logic [7:0]  rld = 8'h00;
  logic [15:0] count;
  logic        req, out_n;

  int    n_chk = 0, n_err = 0;
  string cur_req = "R1";
  bit    finished = 0;

  always #2 clk = ~clk;

  wdog_prescaled u_wdog_prescaled (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .svc_i     (svc),
    .dis_i     (dis),
    .einit_i   (einit),
    .div_sel_i (sel),
    .reload_i  (rld),
    .count_o   (count),
    .rst_req_o (req),
    .rst_out_no(out_n)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_cnt, m_pre, m_en, m_lock, m_act, m_rem;
  int lim, nen, nlock;
  bit tk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_en = 1; m_lock = 0; m_act = 0; m_rem = 0;
    end else if (m_act != 0) begin
      m_rem--;
      if (m_rem == 0) begin
        m_act = 0; m_en = 1; m_lock = 0; m_pre = 0; m_cnt = 0;
      end
    end else begin
      lim   = sel ? 127 : 1;
      tk    = (m_en != 0) && (m_pre >= lim);
      nen   = (dis && m_lock == 0 && !einit) ? 0 : m_en;
      nlock = (m_lock != 0 || einit) ? 1 : 0;
      if (tk && m_cnt == 65535) begin
        m_act = 1; m_rem = PULSE; m_cnt = 0; m_pre = 0;
      end else if (svc) begin
        m_cnt = int'(rld) * 256; m_pre = 0;
      end else if (m_en != 0) begin
        if (tk) begin m_pre = 0; m_cnt++; end
        else m_pre++;
      end
      m_en = nen; m_lock = nlock;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin
      chk(cur_req, "model count", int'(count), m_cnt);
      chk(cur_req, "model req", int'(req), m_act);
      chk(cur_req, "model rst_out_n", int'(out_n), 1 - m_act);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic strobe(input bit s, input bit d, input bit e);
    svc = s; dis = d; einit = e;
    @(negedge clk);
    svc = 1'b0; dis = 1'b0; einit = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int c0;
    // R1 reset state
    cur_req = "R1";
    do_reset();
    chk("R1", "count after reset", int'(count), 0);
    chk("R1", "req after reset", int'(req), 0);
    chk("R1", "rst_out_n after reset", int'(out_n), 1);

    // R2 divide-by-2 rate from reset
    cur_req = "R2";
    repeat (20) @(negedge clk);
    chk("R2", "count after 20 clocks /2", int'(count), 10);

    // R3 service at divide-by-128
    cur_req = "R3";
    sel = 1'b1; rld = 8'hA5;
    strobe(1, 0, 0);
    chk("R3", "count after service", int'(count), 16'hA500);
    repeat (127) @(negedge clk);
    chk("R3", "count 127 clocks after service", int'(count), 16'hA500);
    @(negedge clk);
    chk("R3", "count 128 clocks after service", int'(count), 16'hA501);

    // R4 overflow at divide-by-2 with reload FF
    cur_req = "R4";
    sel = 1'b0; rld = 8'hFF;
    strobe(1, 0, 0);
    repeat (511) @(negedge clk);
    chk("R4", "count before overflow", int'(count), 16'hFFFF);
    chk("R4", "req before overflow", int'(req), 0);
    @(negedge clk);
    chk("R4", "req at overflow", int'(req), 1);
    chk("R4", "rst_out_n at overflow", int'(out_n), 0);
    // R5 inputs ignored during pulse
    cur_req = "R5";
    rld = 8'h77;
    strobe(1, 1, 1);
    chk("R5", "count during pulse after service", int'(count), 0);
    chk("R5", "req during pulse", int'(req), 1);
    repeat (6) @(negedge clk);
    chk("R4", "req at last pulse cycle", int'(req), 1);
    @(negedge clk);
    cur_req = "R6";
    chk("R4", "req after pulse", int'(req), 0);
    chk("R6", "rst_out_n after pulse", int'(out_n), 1);
    chk("R6", "count after pulse", int'(count), 0);
    repeat (2) @(negedge clk);
    chk("R6", "count restarts after pulse", int'(count), 1);

    // R6/R7 window reopened: disable accepted, counter holds
    cur_req = "R7";
    strobe(0, 1, 0);
    c0 = int'(count);
    repeat (50) @(negedge clk);
    chk("R7", "count held while disabled", int'(count), c0);
    rld = 8'h12;
    strobe(1, 0, 0);
    repeat (300) @(negedge clk);
    chk("R7", "service while disabled loads and holds", int'(count), 16'h1200);
    strobe(0, 0, 1);
    repeat (20) @(negedge clk);
    chk("R7", "einit does not re-enable", int'(count), 16'h1200);
    chk("R7", "no reset pulse while disabled", int'(req), 0);

    // R8 disable after end-of-init ignored
    cur_req = "R8";
    do_reset();
    strobe(0, 0, 1);
    strobe(0, 1, 0);
    c0 = int'(count);
    repeat (40) @(negedge clk);
    chk("R8", "counting continues after late disable", int'(count), c0 + 20);
    do_reset();
    strobe(0, 1, 1);
    c0 = int'(count);
    repeat (40) @(negedge clk);
    chk("R8", "same-cycle einit blocks disable", int'(count), c0 + 20);

    // R9 service colliding with overflow tick
    cur_req = "R9";
    do_reset();
    sel = 1'b0; rld = 8'hFF;
    strobe(1, 0, 0);
    repeat (511) @(negedge clk);
    rld = 8'h33;
    strobe(1, 0, 0);
    chk("R9", "overflow wins req", int'(req), 1);
    chk("R9", "overflow wins count", int'(count), 0);
    repeat (PULSE + 2) @(negedge clk);

    // R2 longest-tick interval at divide-by-128
    cur_req = "R2";
    do_reset();
    sel = 1'b1; rld = 8'hFF;
    strobe(1, 0, 0);
    repeat (32767) @(negedge clk);
    chk("R2", "count before slow overflow", int'(count), 16'hFFFF);
    chk("R2", "req before slow overflow", int'(req), 0);
    @(negedge clk);
    chk("R2", "req at slow overflow", int'(req), 1);
    repeat (PULSE + 2) @(negedge clk);

    finish_run();
  end

endmodule